// File: doc/BRIEF.md
# Expansion Bus Decoder and Strobe Generator

This block sits between a 24-bit CPU bus and an expansion connector. It watches the byte address, the address strobe and the two byte-lane write strobes, and it produces active-low selects for several overlapping address windows. It also produces an acknowledge, a row/column address-select line and a column strobe, each placed a fixed number of fine timebase ticks after the address strobe. A narrow write pulse for a peripheral register window is produced as well. That pulse is exactly one CPU clock long and is locked to the fall of a write strobe.

The block runs on a fast system clock. A tick enable (`tick_i`) marks the fine timebase steps. The CPU clock is brought in as a sampled level (`cpu_clk_i`), and only its transitions are used. Every output is registered. All outputs return high on the clock after the address strobe negates.

Top module: `expbus_strobe_gen`

## Requirements
- R1: The ROM-area select goes low for any access, read or write, with an address from 0x400000 to 0x5FFFFF. It goes low on the clock after the address strobe is first sampled low.
- R2: The second-row select goes low for any access with an address from 0x600000 to 0x7FFFFF, on the same timing as R1.
- R3: The address-select output goes low for any access with an address from 0x000000 to 0x7FFFFF, but only once the tick count reaches ASEL_TICKS (default 24).
- R4: The peripheral select goes low for any access with an address from 0xA12000 to 0xA120FF, on the same timing as R1.
- R5: The peripheral write pulse appears only when a write strobe falls during an access to the peripheral window. A write strobe counts as low when either the upper or the lower strobe is low. Reads and writes to other addresses produce no pulse.
- R6: The peripheral write pulse goes low on the clock that samples the write-strobe fall. It ends on the clock that samples the second `cpu_clk_i` transition after that fall, so it lasts one full CPU clock period.
- R7: The tick count is 0 on the clock where the address strobe is first sampled low. It then rises by one on each later clock with `tick_i` high. The acknowledge goes low when the count reaches ACK_TICKS (default 23), for an access in any window. The column strobe goes low when the count reaches CAS_TICKS (default 39), for an access in 0x000000 to 0x7FFFFF.
- R8: On the clock after the address strobe is sampled high, every output is high.
- R9: An address outside every window asserts no output, and that includes the acknowledge.
- R10: During reset every output is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Fine timebase step enable |
| cpu_clk_i | input | 1 | CPU clock level, sampled |
| addr_i | input | 24 | CPU byte address |
| as_n_i | input | 1 | Address strobe, active low |
| uwr_n_i | input | 1 | Upper-byte write strobe, active low |
| lwr_n_i | input | 1 | Lower-byte write strobe, active low |
| rom_sel_n_o | output | 1 | ROM-area select |
| ras2_sel_n_o | output | 1 | Second-row select |
| asel_n_o | output | 1 | Row/column address select |
| periph_sel_n_o | output | 1 | Peripheral window select |
| periph_wr_n_o | output | 1 | One-CPU-clock peripheral write pulse |
| dtack_n_o | output | 1 | Acknowledge |
| cas_n_o | output | 1 | Column strobe |

## Verification
Two functions can act on the same clock. The first is a write pulse that is still running while the address strobe negates. The second is a write-strobe fall sampled on the very clock where `cpu_clk_i` changes. The bench provokes the second case by lowering the write strobe in the same step as a CPU clock transition. In that case the start must win over the transition, and the measured pulse must span exactly two CPU half-periods. For the first case, the bench releases the address strobe a few clocks into a pulse. A behavioural model, built from tick and edge counts, decides on every clock whether the pulse ends through the strobe release or through the second CPU edge. The window overlaps get the same treatment: the delayed strobes are compared for each decoded region, with the tick enable running both continuously and every other clock.

// File: rtl/expbus_pkg.sv
package expbus_pkg;

    localparam int ADDR_W = 24;
    localparam int N_WIN  = 4;

    // window indices
    localparam int W_ROM    = 0;
    localparam int W_RAS2   = 1;
    localparam int W_LOW    = 2;
    localparam int W_PERIPH = 3;

    localparam logic [ADDR_W-1:0] WIN_FIRST [N_WIN] = '{
        24'h400000, 24'h600000, 24'h000000, 24'hA12000
    };
    localparam logic [ADDR_W-1:0] WIN_LAST [N_WIN] = '{
        24'h5FFFFF, 24'h7FFFFF, 24'h7FFFFF, 24'hA120FF
    };

    typedef struct packed {
        logic rom_n;
        logic ras2_n;
        logic asel_n;
        logic periph_n;
        logic pwr_n;
        logic dtack_n;
        logic cas_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '1;

endpackage

// File: rtl/expbus_window.sv
module expbus_window
    import expbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_WIN-1:0]  hit_o
);

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign hit_o[g] = (addr_i >= WIN_FIRST[g]) && (addr_i <= WIN_LAST[g]);
    end

endmodule

// File: rtl/expbus_tickdly.sv
module expbus_tickdly #(
    parameter int ACK_TICKS  = 23,
    parameter int ASEL_TICKS = 24,
    parameter int CAS_TICKS  = 39
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_low_i,
    input  logic       tick_i,
    output logic [2:0] reach_o      // {cas, asel, ack} reached on next state
);

    localparam int MAX_AB = (ACK_TICKS > ASEL_TICKS) ? ACK_TICKS : ASEL_TICKS;
    localparam int MAX_T  = (MAX_AB > CAS_TICKS) ? MAX_AB : CAS_TICKS;
    localparam int CNT_W  = (MAX_T < 1) ? 1 : $clog2(MAX_T + 1);
    localparam int DLY [3] = '{ACK_TICKS, ASEL_TICKS, CAS_TICKS};

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tst_t;

    tst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!as_low_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (tick_i && (int'(st_q.cnt) < MAX_T)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_reach
        assign reach_o[g] = as_low_i && (int'(st_d.cnt) >= DLY[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/expbus_wrpulse.sv
module expbus_wrpulse (
    input  logic clk,
    input  logic rst_n,
    input  logic as_low_i,
    input  logic wr_low_i,
    input  logic hit_i,
    input  logic cpu_clk_i,
    output logic pulse_next_o
);

    typedef struct packed {
        logic wr_prev;
        logic cpu_prev;
        logic lvl;
        logic busy;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_prev  = wr_low_i;
        st_d.cpu_prev = cpu_clk_i;
        if (!as_low_i) begin
            st_d.busy = 1'b0;
        end else if (wr_low_i && !st_q.wr_prev && hit_i) begin
            st_d.busy = 1'b1;
            st_d.lvl  = cpu_clk_i;
        end else if (st_q.busy && (cpu_clk_i == st_q.lvl) && (st_q.cpu_prev != st_q.lvl)) begin
            st_d.busy = 1'b0;
        end
    end

    assign pulse_next_o = st_d.busy && hit_i && as_low_i;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/expbus_strobe_gen.sv
module expbus_strobe_gen
    import expbus_pkg::*;
#(
    parameter int ACK_TICKS  = 23,
    parameter int ASEL_TICKS = 24,
    parameter int CAS_TICKS  = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cpu_clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_n_i,
    input  logic              uwr_n_i,
    input  logic              lwr_n_i,
    output logic              rom_sel_n_o,
    output logic              ras2_sel_n_o,
    output logic              asel_n_o,
    output logic              periph_sel_n_o,
    output logic              periph_wr_n_o,
    output logic              dtack_n_o,
    output logic              cas_n_o
);

    logic [N_WIN-1:0] hit;
    logic [2:0]       reach;
    logic             pulse_next;
    logic             as_low, wr_low, any_hit;
    strobe_t          out_d, out_q;

    assign as_low  = !as_n_i;
    assign wr_low  = !(uwr_n_i && lwr_n_i);
    assign any_hit = |hit;

    expbus_window u_win (
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    expbus_tickdly #(
        .ACK_TICKS  (ACK_TICKS),
        .ASEL_TICKS (ASEL_TICKS),
        .CAS_TICKS  (CAS_TICKS)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_low_i (as_low),
        .tick_i   (tick_i),
        .reach_o  (reach)
    );

    expbus_wrpulse u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_low_i     (as_low),
        .wr_low_i     (wr_low),
        .hit_i        (hit[W_PERIPH]),
        .cpu_clk_i    (cpu_clk_i),
        .pulse_next_o (pulse_next)
    );

    always_comb begin
        out_d          = STROBE_IDLE;
        out_d.rom_n    = !(as_low && hit[W_ROM]);
        out_d.ras2_n   = !(as_low && hit[W_RAS2]);
        out_d.periph_n = !(as_low && hit[W_PERIPH]);
        out_d.asel_n   = !(hit[W_LOW] && reach[1]);
        out_d.dtack_n  = !(any_hit && reach[0]);
        out_d.cas_n    = !(hit[W_LOW] && reach[2]);
        out_d.pwr_n    = !pulse_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= STROBE_IDLE;
        else        out_q <= out_d;
    end

    assign rom_sel_n_o    = out_q.rom_n;
    assign ras2_sel_n_o   = out_q.ras2_n;
    assign asel_n_o       = out_q.asel_n;
    assign periph_sel_n_o = out_q.periph_n;
    assign periph_wr_n_o  = out_q.pwr_n;
    assign dtack_n_o      = out_q.dtack_n;
    assign cas_n_o        = out_q.cas_n;

endmodule

// File: rtl/expbus_strobe_gen_chk.sv
module expbus_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n_i,
    input logic uwr_n_i,
    input logic lwr_n_i,
    input logic rom_sel_n_o,
    input logic ras2_sel_n_o,
    input logic asel_n_o,
    input logic periph_sel_n_o,
    input logic periph_wr_n_o,
    input logic dtack_n_o,
    input logic cas_n_o
);

    assert_idle_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_i |=> (rom_sel_n_o && ras2_sel_n_o && asel_n_o && periph_sel_n_o &&
                    periph_wr_n_o && dtack_n_o && cas_n_o));

    assert_sel_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rom_sel_n_o, !ras2_sel_n_o, !periph_sel_n_o}));

    assert_rom_follows_as_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_sel_n_o) |-> $past(!as_n_i));

    assert_asel_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !asel_n_o |-> !dtack_n_o);

    assert_cas_after_asel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !asel_n_o);

    assert_pulse_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_wr_n_o |-> !periph_sel_n_o);

    assert_pulse_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_wr_n_o) |-> $past(!(uwr_n_i && lwr_n_i)));

endmodule

bind expbus_strobe_gen expbus_strobe_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .as_n_i         (as_n_i),
    .uwr_n_i        (uwr_n_i),
    .lwr_n_i        (lwr_n_i),
    .rom_sel_n_o    (rom_sel_n_o),
    .ras2_sel_n_o   (ras2_sel_n_o),
    .asel_n_o       (asel_n_o),
    .periph_sel_n_o (periph_sel_n_o),
    .periph_wr_n_o  (periph_wr_n_o),
    .dtack_n_o      (dtack_n_o),
    .cas_n_o        (cas_n_o)
);

// File: tb/sim_expbus_strobe_gen.sv
module sim_expbus_strobe_gen;

    localparam int ACK_T  = 23;
    localparam int ASEL_T = 24;
    localparam int CAS_T  = 39;
    localparam int HALF   = 6;     // cpu clock half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        cpu_clk_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        as_n_i = 1'b1;
    logic        uwr_n_i = 1'b1;
    logic        lwr_n_i = 1'b1;
    logic        rom_sel_n_o, ras2_sel_n_o, asel_n_o, periph_sel_n_o;
    logic        periph_wr_n_o, dtack_n_o, cas_n_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit tick_alt = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    expbus_strobe_gen #(.ACK_TICKS(ACK_T), .ASEL_TICKS(ASEL_T), .CAS_TICKS(CAS_T)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cpu_clk_i(cpu_clk_i),
        .addr_i(addr_i), .as_n_i(as_n_i), .uwr_n_i(uwr_n_i), .lwr_n_i(lwr_n_i),
        .rom_sel_n_o(rom_sel_n_o), .ras2_sel_n_o(ras2_sel_n_o), .asel_n_o(asel_n_o),
        .periph_sel_n_o(periph_sel_n_o), .periph_wr_n_o(periph_wr_n_o),
        .dtack_n_o(dtack_n_o), .cas_n_o(cas_n_o)
    );

    // ---------------- behavioural reference model ----------------
    bit m_run, m_busy, m_wrprev, m_cpuprev;
    int m_ticks, m_edges;
    bit e_rom = 1, e_ras2 = 1, e_asel = 1, e_per = 1, e_pwr = 1, e_ack = 1, e_cas = 1;
    bit m_inrst = 1, m_idle = 1, m_nowin = 0;

    always @(posedge clk) begin
        bit as_low, wr_low, in_rom, in_ras2, in_low, in_per;
        int a;
        a       = int'(addr_i);
        as_low  = !as_n_i;
        wr_low  = !uwr_n_i || !lwr_n_i;
        in_rom  = addr_i[23:21] == 3'b010;
        in_ras2 = addr_i[23:21] == 3'b011;
        in_low  = a < 32'h800000;
        in_per  = addr_i[23:8] == 16'hA120;
        m_inrst = !rst_n;
        m_idle  = !as_low;
        m_nowin = !(in_low || in_per);
        if (!rst_n) begin
            m_run = 0; m_busy = 0; m_wrprev = 0; m_cpuprev = 0; m_ticks = 0; m_edges = 0;
            {e_rom, e_ras2, e_asel, e_per, e_pwr, e_ack, e_cas} = '1;
        end else begin
            if (!as_low) begin
                m_run = 0; m_ticks = 0;
            end else if (!m_run) begin
                m_run = 1; m_ticks = 0;
            end else if (tick_i) begin
                m_ticks++;
            end
            if (!as_low) begin
                m_busy = 0;
            end else if (wr_low && !m_wrprev && in_per) begin
                m_busy = 1; m_edges = 0;
            end else if (m_busy) begin
                if (cpu_clk_i != m_cpuprev) m_edges++;
                if (m_edges == 2) m_busy = 0;
            end
            m_wrprev  = wr_low;
            m_cpuprev = cpu_clk_i;
            e_rom  = !(as_low && in_rom);
            e_ras2 = !(as_low && in_ras2);
            e_per  = !(as_low && in_per);
            e_asel = !(as_low && in_low && m_ticks >= ASEL_T);
            e_ack  = !(as_low && (in_low || in_per) && m_ticks >= ACK_T);
            e_cas  = !(as_low && in_low && m_ticks >= CAS_T);
            e_pwr  = !(as_low && in_per && m_busy);
        end
    end

    function automatic string tag(string own);
        if (m_inrst)      return "R10";
        else if (m_idle)  return "R8";
        else if (m_nowin) return "R9";
        return own;
    endfunction

    task automatic cmp(string req, string nm, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, nm, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cmp(tag("R1"), "rom_sel",   rom_sel_n_o,    e_rom);
            cmp(tag("R2"), "ras2_sel",  ras2_sel_n_o,   e_ras2);
            cmp(tag("R3"), "asel",      asel_n_o,       e_asel);
            cmp(tag("R4"), "periph_sel", periph_sel_n_o, e_per);
            cmp(tag("R5"), "periph_wr", periph_wr_n_o,  e_pwr);
            cmp(tag("R7"), "dtack",     dtack_n_o,      e_ack);
            cmp(tag("R7"), "cas",       cas_n_o,        e_cas);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc % HALF == 0) cpu_clk_i = ~cpu_clk_i;
        tick_i = tick_alt ? cyc[0] : 1'b1;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // wr: 0 read, 1 lower only, 2 upper only, 3 both; align: fall on a cpu edge
    task automatic access(logic [23:0] a, int wr, bit align, int hold);
        addr_i = a;
        step();
        as_n_i = 1'b0;
        steps(3);
        if (wr != 0) begin
            if (align) while (cyc % HALF != 0) step();
            lwr_n_i = !wr[0];
            uwr_n_i = !wr[1];
        end
        steps(hold);
        as_n_i = 1'b1; uwr_n_i = 1'b1; lwr_n_i = 1'b1;
        steps(2);
    endtask

    task automatic width_check(int wr);
        int n;
        addr_i = 24'hA12040;
        step();
        as_n_i = 1'b0;
        steps(3);
        while (cyc % HALF != 0) step();
        lwr_n_i = !wr[0];
        uwr_n_i = !wr[1];
        n = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (periph_wr_n_o == 1'b0) n++;
            else if (n > 0) break;
        end
        compared++;
        if (n != 2 * HALF) begin
            mismatched++;
            $display("FAIL R6 pulse width: actual=%0d expected=%0d", n, 2 * HALF);
        end
        steps(10);
        as_n_i = 1'b1; uwr_n_i = 1'b1; lwr_n_i = 1'b1;
        steps(2);
    endtask

    initial begin
        steps(4);
        rst_n = 1'b1;            // R10 reset state compared above
        steps(2);
        for (int pass = 0; pass < 2; pass++) begin
            tick_alt = (pass == 1);
            access(24'h400000, 0, 0, 50 + 40 * pass);   // R1
            access(24'h5FFFFE, 3, 0, 30);               // R1 write
            access(24'h600000, 0, 0, 50 + 40 * pass);   // R2
            access(24'h7FFFFF, 1, 0, 30);               // R2
            access(24'h123456, 0, 0, 50 + 40 * pass);   // R3, R7
            access(24'hA12000, 0, 0, 40);               // R4, R5 read: no pulse
            access(24'hA120FF, 1, 1, 30);               // R5 odd byte
            access(24'hA12002, 2, 0, 30);               // R5 even byte
            access(24'hA12010, 3, 0, 30);               // R5 word
            access(24'hA12100, 3, 0, 30);               // R9 just past window
            access(24'hA11FFF, 3, 0, 30);               // R9 just below window
            access(24'h800000, 0, 0, 50);               // R9
            access(24'hA12080, 3, 1, 3);                // R8 strobe released mid-pulse
        end
        tick_alt = 1'b0;
        width_check(1);   // R6
        width_check(3);   // R6
        // back-to-back cycles with one idle clock
        addr_i = 24'h400010; as_n_i = 1'b0; steps(30);
        as_n_i = 1'b1; step();
        addr_i = 24'hA12004; as_n_i = 1'b0; steps(30);
        as_n_i = 1'b1; steps(3);
        // reset in the middle of an access (R10)
        addr_i = 24'h600100; as_n_i = 1'b0; steps(30);
        rst_n = 1'b0; steps(3);
        as_n_i = 1'b1; rst_n = 1'b1; steps(3);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule